// File: doc/BRIEF.md
# SPI Word Master with Chip-Select Policy

This block is the transfer engine of a serial peripheral interface master that drives a single active-low chip select. A host hands it one word at a time through a valid/ready handshake, together with a target identifier and a flag marking the final word of a sequence. The engine shifts the word out on MOSI while it shifts a word in from MISO. When the word is done it returns the received word with a one-cycle valid pulse.

Configuration inputs set the word length (8 to 16 bits from a 4-bit code), the idle clock level, and the edge on which data is captured. They also set the clock divider and two chip-select policies. The first policy keeps the select asserted after a final word until a word for a different target arrives. The second forces the select inactive after every word. A length code outside the defined range is refused: the engine raises an error pulse and starts nothing.

The configuration must be held steady while a word is in flight and while the select is held low between words.

Top module: `spi_word_master`

## Requirements
- R1: A length code c from 0 to 8 selects N = c + 8 bits. Each word produces exactly 2N SPCK edges and is sent most-significant bit first, using only the low N bits of `tx_data`. `rx_data` carries the N captured bits in its low bits, first bit received as the highest, and its upper bits are zero.
- R2: A length code from 9 to 15 is still taken by the handshake. `len_err` goes high for one cycle, in the cycle after the accepting edge. There are no SPCK edges and no `rx_valid`, `cs_n` does not change, and `tx_ready` stays high.
- R3: While no word is shifting, SPCK rests at `cfg_cpol`: low for 0, high for 1.
- R4: With `cfg_lead_capture` = 0, MOSI changes on leading SPCK edges and MISO is captured on trailing edges. The first bit is driven when the select asserts.
- R5: With `cfg_lead_capture` = 1, MISO is captured on leading SPCK edges and MOSI changes on trailing edges. The first bit is on MOSI before the first SPCK edge.
- R6: With both policies off, `cs_n` rises after the final edge of a word marked last. After a word not marked last, `cs_n` stays low into the next word.
- R7: With `cfg_cs_keep` = 1, `cs_n` stays low after a last word. A following word for the same target keeps it low. A word for a different target first drives `cs_n` high and then low again before shifting.
- R8: With `cfg_cs_pulse` = 1, `cs_n` rises after every word. Every high interval of `cs_n` lasts at least `cfg_div` + 1 clock cycles.
- R9: Consecutive SPCK edges within a word are exactly `cfg_div` + 1 clock cycles apart.
- R10: `busy` is high from select assertion through the final SPCK edge of the word. `busy` is low whenever `tx_ready` is high.
- R11: `rx_valid` is a one-cycle pulse in the clock cycle that follows the edge producing the final SPCK edge of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len_code | input | 4 | Word length code, N = code + 8, codes 9-15 refused |
| cfg_cpol | input | 1 | Idle SPCK level |
| cfg_lead_capture | input | 1 | 1: capture on leading edge, 0: capture on trailing edge |
| cfg_cs_keep | input | 1 | Keep select asserted after a last word until the target changes |
| cfg_cs_pulse | input | 1 | Release select after every word |
| cfg_div | input | DIV_W | SPCK half period minus one, in clock cycles |
| tx_valid | input | 1 | Host presents a word |
| tx_ready | output | 1 | Engine can take a word |
| tx_data | input | WORD_W | Word to send (low N bits used) |
| tx_target | input | TGT_W | Target identifier of the word |
| tx_last | input | 1 | Word ends a sequence |
| rx_valid | output | 1 | Received word pulse |
| rx_data | output | WORD_W | Received word |
| len_err | output | 1 | Refused length code pulse |
| busy | output | 1 | Word in progress |
| spck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
`len_err` is due in the cycle right after the accepting edge. `rx_valid`, the final `cs_n` level and the idle SPCK level are all due in the cycle after the edge that makes the last SPCK transition. SPCK transitions are due every `cfg_div` + 1 cycles. The bench samples every output at the falling clock edge, or 1 ns after it, so each registered result is read one half cycle after the edge that produced it. A serial peripheral model in the same sampler drives MISO and captures MOSI from the observed transitions. The bench sweeps every length, polarity and capture-edge combination with divider values 0 to 3, all seven refused codes, and each chip-select policy sequence.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_SHIFT,
    ST_TAIL
  } spi_state_e;

  localparam logic [3:0] LEN_CODE_MAX = 4'd8;
  localparam logic [4:0] LEN_BASE     = 5'd8;

  function automatic logic len_code_ok(input logic [3:0] code);
    return code <= LEN_CODE_MAX;
  endfunction

  function automatic logic [4:0] len_code_bits(input logic [3:0] code);
    return {1'b0, code} + LEN_BASE;
  endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = !clear && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (cnt == div) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic [LEN_W-1:0]  load_bits,
  input  logic              advance,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] tx_sr;
  logic [LEN_W-1:0]  bits_q;
  logic [IDX_W-1:0]  first_idx;
  logic [IDX_W-1:0]  next_idx;

  assign first_idx = IDX_W'(load_bits - LEN_W'(1));
  assign next_idx  = IDX_W'(bits_q - LEN_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      bits_q  <= '0;
      mosi    <= 1'b0;
      rx_word <= '0;
    end else if (load) begin
      tx_sr   <= load_data;
      bits_q  <= load_bits;
      mosi    <= load_data[first_idx];
      rx_word <= '0;
    end else begin
      if (advance) begin
        tx_sr <= tx_sr << 1;
        mosi  <= tx_sr[next_idx];
      end
      if (sample) begin
        rx_word <= {rx_word[WORD_W-2:0], miso};
      end
    end
  end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  parameter int TGT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cfg_len_code,
  input  logic              cfg_cpol,
  input  logic              cfg_lead_capture,
  input  logic              cfg_cs_keep,
  input  logic              cfg_cs_pulse,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  input  logic [TGT_W-1:0]  tx_target,
  input  logic              tx_last,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              len_err,
  output logic              busy,
  output logic              spck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  localparam int LEN_W  = $clog2(WORD_W + 1);
  localparam int ECNT_W = LEN_W + 1;

  spi_state_e        state;
  logic              cs_n_q, spck_q, busy_q, ready_q, err_q, rxv_q;
  logic              lead_q, keep_q, pulse_q, last_q;
  logic [LEN_W-1:0]  nbits_q;
  logic [ECNT_W-1:0] ecnt;
  logic [TGT_W-1:0]  held_tgt, tgt_q;

  logic              tick, accept, code_ok, load;
  logic              edge_now, lead_edge, final_edge;
  logic              do_sample, do_advance, release_cs;
  logic [LEN_W-1:0]  nbits_in;
  logic [ECNT_W-1:0] last_ecnt;

  assign accept     = tx_valid && ready_q;
  assign code_ok    = len_code_ok(cfg_len_code);
  assign nbits_in   = LEN_W'(len_code_bits(cfg_len_code));
  assign load       = accept && code_ok;

  assign edge_now   = (state == ST_SHIFT) && tick;
  assign lead_edge  = !ecnt[0];
  assign last_ecnt  = ({1'b0, nbits_q} << 1) - ECNT_W'(1);
  assign final_edge = (ecnt == last_ecnt);
  assign do_sample  = edge_now && (lead_q == lead_edge);
  assign do_advance = edge_now && (lead_q != lead_edge) &&
                      !(lead_edge ? (ecnt == '0) : final_edge);
  assign release_cs = pulse_q || (last_q && !keep_q);

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (state == ST_IDLE),
    .div   (cfg_div),
    .tick  (tick)
  );

  spi_word_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (tx_data),
    .load_bits (nbits_in),
    .advance   (do_advance),
    .sample    (do_sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cs_n_q   <= 1'b1;
      spck_q   <= cfg_cpol;
      busy_q   <= 1'b0;
      ready_q  <= 1'b1;
      err_q    <= 1'b0;
      rxv_q    <= 1'b0;
      lead_q   <= 1'b0;
      keep_q   <= 1'b0;
      pulse_q  <= 1'b0;
      last_q   <= 1'b0;
      nbits_q  <= '0;
      ecnt     <= '0;
      held_tgt <= '0;
      tgt_q    <= '0;
    end else begin
      err_q <= 1'b0;
      rxv_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          spck_q <= cfg_cpol;
          if (accept) begin
            if (!code_ok) begin
              err_q <= 1'b1;
            end else begin
              ready_q <= 1'b0;
              lead_q  <= cfg_lead_capture;
              keep_q  <= cfg_cs_keep;
              pulse_q <= cfg_cs_pulse;
              last_q  <= tx_last;
              nbits_q <= nbits_in;
              tgt_q   <= tx_target;
              ecnt    <= '0;
              if (!cs_n_q && (tx_target != held_tgt)) begin
                cs_n_q <= 1'b1;
                state  <= ST_GAP;
              end else begin
                cs_n_q   <= 1'b0;
                busy_q   <= 1'b1;
                held_tgt <= tx_target;
                state    <= ST_SHIFT;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            cs_n_q   <= 1'b0;
            busy_q   <= 1'b1;
            held_tgt <= tgt_q;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            spck_q <= ~spck_q;
            ecnt   <= ecnt + 1'b1;
            if (final_edge) begin
              busy_q <= 1'b0;
              rxv_q  <= 1'b1;
              if (release_cs) begin
                cs_n_q <= 1'b1;
                state  <= ST_TAIL;
              end else begin
                ready_q <= 1'b1;
                state   <= ST_IDLE;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            ready_q <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready = ready_q;
  assign rx_valid = rxv_q;
  assign len_err  = err_q;
  assign busy     = busy_q;
  assign spck     = spck_q;
  assign cs_n     = cs_n_q;

endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic spck,
  input logic busy,
  input logic tx_ready,
  input logic rx_valid,
  input logic len_err
);

  // R10: a word in progress always has the select asserted
  a_r10_busy_needs_cs: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n);

  // R10: the handshake is open only between words
  a_r10_ready_not_busy: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !busy);

  // R11: one received-word pulse per completed word
  a_r11_rx_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R2: a refused code leaves the select untouched
  a_r2_err_keeps_cs: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $stable(cs_n));

  // R2: a refused code starts no word
  a_r2_err_not_busy: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !busy);

  // R3: with the select low, SPCK moves only while a word is shifting
  a_r3_clock_only_in_word: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$stable(spck)) |-> $past(busy));

endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .spck     (spck),
  .busy     (busy),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .len_err  (len_err)
);

// File: tb/spi_word_master_test.sv
`timescale 1ns/1ps
module spi_word_master_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_len_code = 4'd0;
  logic        cfg_cpol = 1'b0;
  logic        cfg_lead_capture = 1'b0;
  logic        cfg_cs_keep = 1'b0;
  logic        cfg_cs_pulse = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] tx_data = 16'h0;
  logic [1:0]  tx_target = 2'd0;
  logic        tx_last = 1'b0;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        len_err;
  logic        busy;
  logic        spck;
  logic        mosi;
  logic        miso = 1'b0;
  logic        cs_n;

  always #2 clk = ~clk;

  spi_word_master uut (
    .clk(clk), .rst(rst), .cfg_len_code(cfg_len_code), .cfg_cpol(cfg_cpol),
    .cfg_lead_capture(cfg_lead_capture), .cfg_cs_keep(cfg_cs_keep),
    .cfg_cs_pulse(cfg_cs_pulse), .cfg_div(cfg_div), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_target(tx_target),
    .tx_last(tx_last), .rx_valid(rx_valid), .rx_data(rx_data),
    .len_err(len_err), .busy(busy), .spck(spck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sword(input int i);
    return 16'h9C35 ^ 16'(i * 16'h2B71);
  endfunction

  function automatic logic [15:0] msk(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  // peripheral model and timing monitor
  int          cur_n = 8;
  int          cyc = 0, ec = 0, sw = 0, nsent = 0;
  int          tog_cnt = 0, rises = 0, high_run = 0, prev_cyc = 0, rxv_cnt = 0;
  bit          have_prev = 0;
  logic        spck_prev, cs_prev;
  logic [15:0] stx = 16'h0, srx = 16'h0;
  logic [15:0] got [256];

  always @(negedge clk) begin
    if (rst) begin
      spck_prev = spck;
      cs_prev   = cs_n;
    end else begin
      bit tg;
      cyc++;
      tg = (spck != spck_prev);
      spck_prev = spck;
      if (cs_prev && !cs_n) begin
        chk(high_run >= int'(cfg_div) + 1, "R8 select high interval", high_run, int'(cfg_div) + 1);
        ec = 0; srx = 0; stx = sword(sw); miso = stx[cur_n-1];
      end
      if (!cs_prev && cs_n) rises++;
      high_run = cs_n ? high_run + 1 : 0;
      cs_prev = cs_n;
      if (tg && (!cs_n || rx_valid)) begin
        int k;
        if (have_prev)
          chk(cyc - prev_cyc == int'(cfg_div) + 1, "R9 edge spacing", cyc - prev_cyc, int'(cfg_div) + 1);
        prev_cyc = cyc; have_prev = 1; tog_cnt++;
        chk(busy == !rx_valid, "R10 busy during word", busy, !rx_valid);
        k = ec / 2;
        if (ec % 2 == 0) begin
          if (cfg_lead_capture) srx = {srx[14:0], mosi};
          else miso = stx[cur_n-1-k];
        end else begin
          if (cfg_lead_capture) begin
            if (k + 1 < cur_n) miso = stx[cur_n-2-k];
          end else srx = {srx[14:0], mosi};
        end
        ec++;
        if (ec == 2 * cur_n) begin
          got[sw] = srx; sw++; ec = 0; srx = 0;
          stx = sword(sw); miso = stx[cur_n-1];
        end
      end
      if (rx_valid) begin
        chk(tg, "R11 rx_valid right after final edge", tg, 1);
        have_prev = 0;
        rxv_cnt++;
      end
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] d, input logic [1:0] tg, input bit last, input string cs_tag);
    bit resv;
    logic cs_before;
    int rc, idx;
    logic [15:0] er;
    wait_ready();
    resv = (cfg_len_code > 4'd8);
    tx_data = d; tx_target = tg; tx_last = last; tx_valid = 1'b1; tog_cnt = 0;
    @(negedge clk); #1;
    tx_valid = 1'b0;
    if (resv) begin
      chk(len_err == 1'b1, "R2 error pulse", len_err, 1);
      cs_before = cs_n; rc = rxv_cnt;
      repeat (12) @(negedge clk);
      #1;
      chk(tog_cnt == 0, "R2 no clock edges", tog_cnt, 0);
      chk(rxv_cnt == rc, "R2 no received word", rxv_cnt, rc);
      chk(cs_n == cs_before, "R2 select unchanged", cs_n, cs_before);
      chk(tx_ready == 1'b1 && len_err == 1'b0, "R2 ready again, pulse over", {tx_ready, len_err}, 2'b10);
    end else begin
      idx = nsent; nsent++;
      forever begin
        @(negedge clk); #1;
        if (rx_valid) break;
      end
      er = sword(idx) & msk(cur_n);
      chk(rx_data == er, cfg_lead_capture ? "R5 captured word" : "R4 captured word", rx_data, er);
      chk(got[idx] == (d & msk(cur_n)), cfg_lead_capture ? "R5 sent word" : "R4 sent word",
          got[idx], d & msk(cur_n));
      chk(tog_cnt == 2 * cur_n, "R1 edge count", tog_cnt, 2 * cur_n);
      chk(spck == cfg_cpol, "R3 idle level", spck, cfg_cpol);
      chk(cs_n == (cfg_cs_pulse || (last && !cfg_cs_keep)), cs_tag, cs_n,
          cfg_cs_pulse || (last && !cfg_cs_keep));
      @(negedge clk); #1;
      chk(!rx_valid, "R11 single pulse", rx_valid, 0);
    end
  endtask

  task automatic set_cfg(input int code, input bit cp, input bit lc, input int dv);
    wait_ready();
    cfg_len_code = 4'(code); cfg_cpol = cp; cfg_lead_capture = lc; cfg_div = 8'(dv);
    if (code <= 8) cur_n = code + 8;
  endtask

  initial begin
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(cs_n == 1'b1 && busy == 1'b0, "R10 reset select and busy", {cs_n, busy}, 2'b10);
    chk(tx_ready == 1'b1 && rx_valid == 1'b0 && len_err == 1'b0, "R2 reset handshake",
        {tx_ready, rx_valid, len_err}, 3'b100);
    chk(spck == cfg_cpol, "R3 reset idle level", spck, cfg_cpol);

    // length x polarity x capture edge, divider 0..3
    for (int cp = 0; cp < 2; cp++)
      for (int lc = 0; lc < 2; lc++)
        for (int code = 0; code <= 8; code++) begin
          set_cfg(code, cp[0], lc[0], (code + 2 * lc + cp) % 4);
          send(16'hF0A5 ^ 16'(code * 16'h1111) ^ 16'(lc << 7), 2'd0, 1'b1, "R6 release after last");
        end

    // refused length codes
    for (int code = 9; code < 16; code++) begin
      set_cfg(code, 1'b0, 1'b0, 1);
      send(16'h1234, 2'd0, 1'b1, "R2");
    end

    // multi-word sequence, select held between words
    set_cfg(3, 1'b0, 1'b1, 1);
    r0 = rises;
    send(16'h0ABC, 2'd0, 1'b0, "R6 held between words");
    send(16'h0555, 2'd0, 1'b0, "R6 held between words");
    chk(rises == r0, "R6 no release mid sequence", rises, r0);
    send(16'h07E1, 2'd0, 1'b1, "R6 release after last");
    chk(rises == r0 + 1, "R6 one release per sequence", rises, r0 + 1);

    // forced release after every word
    wait_ready();
    cfg_cs_pulse = 1'b1;
    set_cfg(5, 1'b1, 1'b0, 2);
    send(16'h3C3C, 2'd0, 1'b0, "R8 release each word");
    send(16'h1F0F, 2'd0, 1'b0, "R8 release each word");
    send(16'h2222, 2'd0, 1'b0, "R8 release each word");

    // keep select across sequences until the target changes
    wait_ready();
    cfg_cs_pulse = 1'b0; cfg_cs_keep = 1'b1;
    set_cfg(0, 1'b0, 1'b1, 1);
    send(16'h00A6, 2'd1, 1'b1, "R7 keep after last");
    r0 = rises;
    send(16'h005B, 2'd1, 1'b1, "R7 keep after last");
    chk(rises == r0, "R7 same target keeps select", rises, r0);
    send(16'h00C3, 2'd2, 1'b1, "R7 keep after last");
    chk(rises == r0 + 1, "R7 new target releases first", rises, r0 + 1);
    wait_ready();
    cfg_cs_keep = 1'b0;
    send(16'h0099, 2'd2, 1'b1, "R7 release once keep is off");

    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule